// File: doc/BRIEF.md
# Per-Bit Access-Attribute Configuration Register Bank

This block is a small configuration register space for a bus bridge. Each field has its own access rule instead of one read/write rule for the whole register. The rules are: constant read-only, plain read/write, write-one-to-clear status, write-once after power-up, and read/write that freezes when a lock bit is set. Software reaches the bank through a simple synchronous port. That port carries a 32-bit word address, 32-bit write data with four byte-lane strobes, and a read strobe whose data returns on the next cycle.

Hardware raises status bits through a side input. The write-once field takes its power-up value from strap pins, which are captured once just after reset releases. One register holds a 3-bit I/O drive-strength code, and the block exports that code both as a binary value and as a one-hot select. The codes 0 through 7 stand for multipliers 0.75, 1.00, 1.25, 1.50, 2.00, 2.50, 3.00 and 4.00, and code 0 is the reset value.

Word map (word index = byte offset / 4): 0 identity, 1 status, 2 write-once, 3 lock/lockable, 13 drive strength (byte offset 0x34).

Top module: `cfg_attr_bank`

## Requirements
- R1: After reset the outputs take these values. Status is 0, the lock bit is 0, the lockable field is 0, the drive code is 0 and drive select is 8'h01. A read of word 0 returns the ID_VALUE parameter.
- R2: Word 0 is read-only and ignores every write. In word 13, bits 31:3 always read 0.
- R3: Status (word 1, bits STAT_W-1:0) clears a bit when software writes 1 to it with byte 0 strobed. Writing 0 leaves the bit unchanged. A 1 on hw_set_i sets the matching bit on the next cycle.
- R4: When hw_set_i and a software clear hit the same status bit in the same cycle, the bit stays 1.
- R5: Each byte lane of word 2 accepts only its first strobed write after reset and ignores later writes. A write that does not strobe a lane does not use up that lane.
- R6: The word 2 value at power-up equals strap_i as sampled on the first clock edge after reset releases. Later changes on strap_i have no effect.
- R7: Word 3 bit 0 is the lock bit. Writing 1 to it sets it, and only reset clears it, so writing 0 has no effect. Bits 15:8 of word 3 are read/write while the lock is 0 and ignore writes once the lock is 1. Word 3 reads as {16'b0, field, 7'b0, lock}.
- R8: Bits 2:0 of word 13 hold the read/write drive code. drv_code_o equals that code and drv_sel_o equals 1 << code.
- R9: Reads of unmapped words return 0, and writes to them change nothing.
- R10: A write changes only the bytes whose strobe bit is set. wstrb_i[k] covers wdata_i[8k+7:8k].
- R11: rdata_o updates on the clock edge that samples rd_i high and holds its value while rd_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Word address |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| wstrb_i | input | 4 | Byte-lane write enables |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, one cycle after rd_i |
| hw_set_i | input | 8 | Hardware set for status bits |
| strap_i | input | 32 | Power-up value for the write-once word |
| status_o | output | 8 | Status bits |
| once_o | output | 32 | Write-once word |
| lock_o | output | 1 | Lock bit |
| lockable_o | output | 8 | Lockable field |
| drv_code_o | output | 3 | Drive-strength code |
| drv_sel_o | output | 8 | One-hot drive-strength select |

## Verification
The assertions check these properties on every cycle:
- drive select is one-hot and matches the code;
- the lock bit is sticky, and the lockable field is frozen while the lock is set;
- a hardware set always lands, even against a clear;
- no status bit rises without a hardware set;
- reads of unmapped words return zero.

Only the bench scenarios can show the following:
- lanes that have already been written ignore later writes;
- strap capture ignores strap changes after reset;
- byte strobes leave the other lanes untouched;
- the identity word stays constant.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  localparam int ADDR_W  = 6;
  localparam int DATA_W  = 32;
  localparam int LANES   = DATA_W / 8;
  localparam int DRV_W   = 3;
  localparam int DRV_N   = 1 << DRV_W;

  localparam logic [ADDR_W-1:0] A_ID   = 6'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 6'd1;
  localparam logic [ADDR_W-1:0] A_ONCE = 6'd2;
  localparam logic [ADDR_W-1:0] A_LOCK = 6'd3;
  localparam logic [ADDR_W-1:0] A_DRV  = 6'd13;

  function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
    return (a == A_ID) || (a == A_STAT) || (a == A_ONCE) ||
           (a == A_LOCK) || (a == A_DRV);
  endfunction
endpackage

// File: rtl/cfg_w1c_field.sv
module cfg_w1c_field #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  // set wins over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= (q & ~clr_i) | set_i;
  end
  assign q_o = q;
endmodule

// File: rtl/cfg_once_lane.sv
module cfg_once_lane (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] strap_i,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] q_o
);
  logic [7:0] q;
  logic       used_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q      <= '0;
      used_q <= 1'b0;
    end else if (load_i) begin
      q <= strap_i;
    end else if (we_i && !used_q) begin
      q      <= wdata_i;
      used_q <= 1'b1;
    end
  end
  assign q_o = q;
endmodule

// File: rtl/cfg_lock_field.sv
module cfg_lock_field #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         lock_set_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic         lock_o,
  output logic [W-1:0] q_o
);
  logic         lock_q;
  logic [W-1:0] q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_q <= 1'b0;
      q      <= '0;
    end else begin
      if (lock_set_i)        lock_q <= 1'b1;
      if (we_i && !lock_q)   q      <= wdata_i;
    end
  end
  assign lock_o = lock_q;
  assign q_o    = q;
endmodule

// File: rtl/cfg_drv_strength.sv
module cfg_drv_strength #(
  parameter int CW = 3,
  localparam int N = 1 << CW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [CW-1:0] wdata_i,
  output logic [CW-1:0] code_o,
  output logic [N-1:0]  sel_o
);
  logic [CW-1:0] code_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   code_q <= '0;
    else if (we_i) code_q <= wdata_i;
  end
  assign code_o = code_q;
  for (genvar i = 0; i < N; i++) begin : g_sel
    assign sel_o[i] = (code_q == CW'(i));
  end
endmodule

// File: rtl/cfg_attr_bank.sv
module cfg_attr_bank
  import cfg_bank_pkg::*;
#(
  parameter logic [31:0] ID_VALUE = 32'h1A2B_3C4D,
  parameter int          STAT_W   = 8,
  parameter int          LCK_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  wstrb_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [STAT_W-1:0] hw_set_i,
  input  logic [DATA_W-1:0] strap_i,
  output logic [STAT_W-1:0] status_o,
  output logic [DATA_W-1:0] once_o,
  output logic              lock_o,
  output logic [LCK_W-1:0]  lockable_o,
  output logic [DRV_W-1:0]  drv_code_o,
  output logic [DRV_N-1:0]  drv_sel_o
);
  localparam int LCK_LO = 8;

  logic [DATA_W-1:0] bmask;
  logic              init_q;
  logic              wr_stat, wr_once, wr_lock, wr_drv;
  logic [DATA_W-1:0] rmux, rdata_q;

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign bmask[l*8 +: 8] = {8{wstrb_i[l]}};
  end

  assign wr_stat = wr_i && (addr_i == A_STAT);
  assign wr_once = wr_i && (addr_i == A_ONCE);
  assign wr_lock = wr_i && (addr_i == A_LOCK);
  assign wr_drv  = wr_i && (addr_i == A_DRV);

  // strap capture on first edge after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) init_q <= 1'b1;
    else         init_q <= 1'b0;
  end

  cfg_w1c_field #(.W(STAT_W)) u_stat (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hw_set_i),
    .clr_i  ({STAT_W{wr_stat}} & wdata_i[STAT_W-1:0] & bmask[STAT_W-1:0]),
    .q_o    (status_o)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_once
    cfg_once_lane u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .load_i  (init_q),
      .strap_i (strap_i[l*8 +: 8]),
      .we_i    (wr_once && wstrb_i[l]),
      .wdata_i (wdata_i[l*8 +: 8]),
      .q_o     (once_o[l*8 +: 8])
    );
  end

  cfg_lock_field #(.W(LCK_W)) u_lock (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lock_set_i (wr_lock && wstrb_i[0] && wdata_i[0]),
    .we_i       (wr_lock && wstrb_i[1]),
    .wdata_i    (wdata_i[LCK_LO +: LCK_W]),
    .lock_o     (lock_o),
    .q_o        (lockable_o)
  );

  cfg_drv_strength #(.CW(DRV_W)) u_drv (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_drv && wstrb_i[0]),
    .wdata_i (wdata_i[DRV_W-1:0]),
    .code_o  (drv_code_o),
    .sel_o   (drv_sel_o)
  );

  always_comb begin
    rmux = '0;
    case (addr_i)
      A_ID:   rmux = ID_VALUE;
      A_STAT: rmux[STAT_W-1:0] = status_o;
      A_ONCE: rmux = once_o;
      A_LOCK: begin
        rmux[0]                = lock_o;
        rmux[LCK_LO +: LCK_W]  = lockable_o;
      end
      A_DRV:  rmux[DRV_W-1:0] = drv_code_o;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rmux;
  end
  assign rdata_o = rdata_q;
endmodule

// File: rtl/cfg_attr_bank_chk.sv
module cfg_attr_bank_chk
  import cfg_bank_pkg::*;
#(
  parameter int STAT_W = 8,
  parameter int LCK_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [STAT_W-1:0] hw_set_i,
  input logic [STAT_W-1:0] status_o,
  input logic              lock_o,
  input logic [LCK_W-1:0]  lockable_o,
  input logic [DRV_W-1:0]  drv_code_o,
  input logic [DRV_N-1:0]  drv_sel_o
);
  a_r8_sel_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(drv_sel_o) == 1);

  a_r8_sel_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_sel_o[drv_code_o] == 1'b1);

  a_r7_lock_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> lock_o);

  a_r7_locked_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |=> $stable(lockable_o));

  a_r4_hw_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hw_set_i) |=> ((status_o & $past(hw_set_i)) == $past(hw_set_i)));

  a_r3_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ((status_o & ~$past(status_o) & ~$past(hw_set_i)) == '0));

  a_r9_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !is_mapped(addr_i)) |=> (rdata_o == '0));
endmodule

bind cfg_attr_bank cfg_attr_bank_chk #(.STAT_W(STAT_W), .LCK_W(LCK_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_i       (rd_i),
  .addr_i     (addr_i),
  .rdata_o    (rdata_o),
  .hw_set_i   (hw_set_i),
  .status_o   (status_o),
  .lock_o     (lock_o),
  .lockable_o (lockable_o),
  .drv_code_o (drv_code_o),
  .drv_sel_o  (drv_sel_o)
);

// File: tb/cfg_attr_bank_tb.sv
module cfg_attr_bank_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [5:0]  addr_i = '0;
  logic        wr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [3:0]  wstrb_i = '0;
  logic        rd_i = 1'b0;
  logic [31:0] rdata_o;
  logic [7:0]  hw_set_i = '0;
  logic [31:0] strap_i = '0;
  logic [7:0]  status_o;
  logic [31:0] once_o;
  logic        lock_o;
  logic [7:0]  lockable_o;
  logic [2:0]  drv_code_o;
  logic [7:0]  drv_sel_o;

  int n_cmp = 0;
  int n_fail = 0;
  bit finished = 0;
  logic rd_d = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk_i = ~clk_i;

  cfg_attr_bank u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .wstrb_i(wstrb_i), .rd_i(rd_i), .rdata_o(rdata_o),
    .hw_set_i(hw_set_i), .strap_i(strap_i), .status_o(status_o),
    .once_o(once_o), .lock_o(lock_o), .lockable_o(lockable_o),
    .drv_code_o(drv_code_o), .drv_sel_o(drv_sel_o)
  );

  always @(posedge clk_i) rd_d <= rd_i;

  // monitor: pop expected read data one cycle after each read
  always @(negedge clk_i) begin
    if (rd_d) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_fail++;
        $display("FAIL R11 unexpected read data got=%h exp=none", rdata_o);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (rdata_o !== e) begin
          n_fail++;
          $display("FAIL %s got=%h exp=%h", t, rdata_o, e);
        end
      end
    end
  end

  task automatic check(input string t, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", t, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] s);
    wr_i = 1'b1; addr_i = a; wdata_i = d; wstrb_i = s;
    @(negedge clk_i);
    wr_i = 1'b0; wstrb_i = '0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_cmp++; n_fail++;
    $display("FAIL watchdog expired got=hang exp=done");
    finish_run();
  end

  initial begin
    strap_i = 32'hA5C3_1E7F;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    strap_i = 32'h0000_0000;       // R6: late change must be ignored

    // R1 reset state
    check("R1 status", {24'b0, status_o}, 32'h0);
    check("R1 lock", {31'b0, lock_o}, 32'h0);
    check("R1 lockable", {24'b0, lockable_o}, 32'h0);
    check("R1 drv_sel", {24'b0, drv_sel_o}, 32'h01);
    rd(6'd0, 32'h1A2B_3C4D, "R1 id read");
    rd(6'd13, 32'h0, "R1 drive reset");
    rd(6'd2, 32'hA5C3_1E7F, "R6 strap capture");

    // R2 read-only identity
    wr(6'd0, 32'hFFFF_FFFF, 4'hF);
    rd(6'd0, 32'h1A2B_3C4D, "R2 id ignores write");

    // R3 / R4 status
    hw_set_i = 8'h5A; @(negedge clk_i); hw_set_i = '0;
    check("R3 hw set", {24'b0, status_o}, 32'h5A);
    wr(6'd1, 32'h0F, 4'h1);
    rd(6'd1, 32'h50, "R3 w1c clear");
    wr(6'd1, 32'hFF, 4'h0);
    rd(6'd1, 32'h50, "R10 unstrobed clear ignored");
    hw_set_i = 8'h10;
    wr(6'd1, 32'h10, 4'h1);
    hw_set_i = '0;
    rd(6'd1, 32'h50, "R4 set beats clear");
    wr(6'd1, 32'h50, 4'h1);
    check("R3 clear all", {24'b0, status_o}, 32'h0);

    // R5 write-once per lane
    wr(6'd2, 32'h1234_5678, 4'h1);
    rd(6'd2, 32'hA5C3_1E78, "R5 first lane0 write");
    wr(6'd2, 32'hFFFF_FFFF, 4'h3);
    rd(6'd2, 32'hA5C3_FF78, "R5 lane0 locked lane1 taken");
    wr(6'd2, 32'h0000_0000, 4'hF);
    check("R5 lanes 2,3 taken", once_o, 32'h0000_FF78);
    wr(6'd2, 32'hFFFF_FFFF, 4'hF);
    rd(6'd2, 32'h0000_FF78, "R5 all lanes ignore");

    // R7 lock / R10 strobes
    wr(6'd3, 32'h0000_AB00, 4'h2);
    rd(6'd3, 32'h0000_AB00, "R7 lockable write");
    wr(6'd3, 32'h0000_CD00, 4'h1);
    rd(6'd3, 32'h0000_AB00, "R10 lane1 unstrobed");
    wr(6'd3, 32'h0000_0001, 4'h1);
    check("R7 lock set", {31'b0, lock_o}, 32'h1);
    wr(6'd3, 32'h0000_1200, 4'h3);
    rd(6'd3, 32'h0000_AB01, "R7 locked field and sticky lock");

    // R8 drive strength
    wr(6'd13, 32'hFFFF_FFFF, 4'h1);
    rd(6'd13, 32'h0000_0007, "R2 drive reserved zero");
    check("R8 sel code7", {24'b0, drv_sel_o}, 32'h80);
    wr(6'd13, 32'h0000_0002, 4'h1);
    check("R8 code2", {29'b0, drv_code_o}, 32'h2);
    check("R8 sel code2", {24'b0, drv_sel_o}, 32'h04);
    wr(6'd13, 32'h0000_0005, 4'h0);
    check("R10 drive unstrobed", {29'b0, drv_code_o}, 32'h2);

    // R9 unmapped
    wr(6'd16, 32'hDEAD_BEEF, 4'hF);
    rd(6'd16, 32'h0, "R9 unmapped read");
    rd(6'd4, 32'h0, "R9 unmapped word4");

    // R11 hold while idle
    @(negedge clk_i);
    check("R11 rdata holds", rdata_o, 32'h0);
    rd(6'd0, 32'h1A2B_3C4D, "R11 read latency");
    repeat (2) @(negedge clk_i);
    check("R11 rdata held", rdata_o, 32'h1A2B_3C4D);
    finish_run();
  end
endmodule